// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address made of a segment number and an offset into a physical address. It uses a small table with one entry per segment. Each entry holds a start address, a length limit and a valid bit. A lookup adds the offset to the selected entry's start address. It returns the sum one clock later, together with a strobe.

If the offset is not below the entry's limit, or the entry is not valid, the block does not return an address. Instead it pulses a segment-fault interrupt, so that the operating system can stop the offending program. Offsets are unsigned, so an access can never land before the start of its segment.

The table is loaded through a write port. That port only takes effect while the processor is in system mode. A write attempted in user mode leaves the table unchanged.

Top module: `seg_xlat_top`

## Requirements
- R1: The logical address is split into two fields. The upper `SEG_W` bits (default 3) select the table entry. The lower `OFF_W` bits (default 12) are the offset.
- R2: On a legal lookup, `pa_addr` equals the entry's start address plus the zero-extended offset, modulo 2^`PA_W` (default 20 bits).
- R3: A lookup is legal only when the unsigned offset is strictly less than the entry's limit. An offset equal to or above the limit raises `seg_fault` and gives no `pa_valid`. The limit is `OFF_W+1` bits wide, so a limit of 2^`OFF_W` admits every offset, and a limit of 0 admits none.
- R4: A lookup of an entry whose valid bit is 0 raises `seg_fault` and gives no `pa_valid`.
- R5: Each lookup strobe on `la_valid` produces, in the next cycle, exactly one of `pa_valid` or `seg_fault`. A cycle without a strobe produces neither in the following cycle.
- R6: A table write (`tw_en`=1) takes effect only when `sys_mode`=1 (1 means system mode, 0 means user mode). A write with `sys_mode`=0 leaves the table unchanged.
- R7: A lookup made in the same cycle as a write to the same entry uses the old contents. Lookups from the next cycle onward use the new contents.
- R8: Synchronous active-high reset clears `pa_valid`, `seg_fault` and `pa_addr`, and marks every entry invalid.
- R9: `pa_addr` reads 0 in any cycle where `pa_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| la_valid | input | 1 | Lookup strobe |
| la_addr | input | SEG_W+OFF_W | Logical address: segment number above offset |
| sys_mode | input | 1 | 1 = system mode, 0 = user mode |
| tw_en | input | 1 | Table write request |
| tw_index | input | SEG_W | Entry to write |
| tw_base | input | PA_W | Start address to store |
| tw_limit | input | OFF_W+1 | Segment length to store |
| tw_valid | input | 1 | Valid bit to store |
| pa_valid | output | 1 | Physical address strobe |
| pa_addr | output | PA_W | Physical address |
| seg_fault | output | 1 | Segment-fault interrupt pulse |

## Verification
The assertions check several properties on every cycle:
- every lookup strobe yields exactly one outcome one cycle later, and no outcome appears without a strobe;
- the address bus is zero outside a valid strobe;
- the table contents hold still in any cycle without a system-mode write;
- outputs are cleared after reset.

The bench scenarios cover what needs a model of the table:
- the sum of start address and offset, including wrap-around past the top of the physical space;
- the exact boundary where an offset equal to the limit faults;
- faults on invalid and zero-length entries;
- the ordering rule when a write and a lookup of the same entry share a cycle.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    parameter int SEG_W = 3;
    parameter int OFF_W = 12;
    parameter int PA_W  = 20;

    localparam int NUM_SEG = 1 << SEG_W;
    localparam int LIM_W   = OFF_W + 1;
    localparam int LA_W    = SEG_W + OFF_W;

    typedef struct packed {
        logic             valid;
        logic [LIM_W-1:0] limit;
        logic [PA_W-1:0]  base;
    } seg_entry_t;

    localparam int ENTRY_W = $bits(seg_entry_t);

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
    } log_addr_t;

    typedef enum logic {
        MODE_USER = 1'b0,
        MODE_SYS  = 1'b1
    } cpu_mode_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_OK    = 2'd1,
        RES_FAULT = 2'd2
    } xlat_res_e;

    function automatic logic offset_in_range(input logic [OFF_W-1:0] off,
                                             input logic [LIM_W-1:0] limit);
        return {1'b0, off} < limit;
    endfunction

    function automatic logic [PA_W-1:0] phys_sum(input logic [PA_W-1:0]  base,
                                                 input logic [OFF_W-1:0] off);
        return base + PA_W'(off);
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlat_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  cpu_mode_e                  mode,
    input  logic [SEG_W-1:0]           wr_idx,
    input  seg_entry_t                 wr_entry,
    input  logic [SEG_W-1:0]           rd_idx,
    output seg_entry_t                 rd_entry,
    output logic [NUM_SEG*ENTRY_W-1:0] table_bits
);

    // Write is gated by the privilege level before any entry decodes it.
    logic wr_allowed;
    assign wr_allowed = wr_en && (mode == MODE_SYS);

    seg_entry_t entry_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
        logic hit;
        assign hit = wr_allowed && (wr_idx == SEG_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (hit) begin
                entry_q[g] <= wr_entry;
            end
        end

        assign table_bits[g*ENTRY_W +: ENTRY_W] = entry_q[g];
    end

    // Read sees the registered contents, so a same-cycle write is not visible yet.
    assign rd_entry = entry_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
(
    input  logic            req_valid,
    input  log_addr_t       la,
    input  seg_entry_t      ent,
    output xlat_res_e       res,
    output logic [PA_W-1:0] pa
);

    logic legal;

    always_comb begin
        legal = ent.valid && offset_in_range(la.off, ent.limit);
        pa    = '0;
        if (!req_valid) begin
            res = RES_NONE;
        end else if (legal) begin
            res = RES_OK;
            pa  = phys_sum(ent.base, la.off);
        end else begin
            res = RES_FAULT;
        end
    end

endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
    import seg_xlat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  xlat_res_e       res_d,
    input  logic [PA_W-1:0] pa_d,
    output logic            ok_q,
    output logic            fault_q,
    output logic [PA_W-1:0] pa_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q    <= 1'b0;
            fault_q <= 1'b0;
            pa_q    <= '0;
        end else begin
            ok_q    <= (res_d == RES_OK);
            fault_q <= (res_d == RES_FAULT);
            pa_q    <= (res_d == RES_OK) ? pa_d : '0;
        end
    end

endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
    import seg_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             la_valid,
    input  logic [LA_W-1:0]  la_addr,
    input  logic             sys_mode,
    input  logic             tw_en,
    input  logic [SEG_W-1:0] tw_index,
    input  logic [PA_W-1:0]  tw_base,
    input  logic [LIM_W-1:0] tw_limit,
    input  logic             tw_valid,
    output logic             pa_valid,
    output logic [PA_W-1:0]  pa_addr,
    output logic             seg_fault
);

    log_addr_t                  la;
    seg_entry_t                 wr_entry;
    seg_entry_t                 rd_entry;
    cpu_mode_e                  mode;
    xlat_res_e                  res;
    logic [PA_W-1:0]            pa_comb;
    logic [NUM_SEG*ENTRY_W-1:0] tbl_bits;

    assign la   = log_addr_t'(la_addr);
    assign mode = sys_mode ? MODE_SYS : MODE_USER;

    always_comb begin
        wr_entry       = '0;
        wr_entry.valid = tw_valid;
        wr_entry.limit = tw_limit;
        wr_entry.base  = tw_base;
    end

    seg_table i_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (tw_en),
        .mode       (mode),
        .wr_idx     (tw_index),
        .wr_entry   (wr_entry),
        .rd_idx     (la.seg),
        .rd_entry   (rd_entry),
        .table_bits (tbl_bits)
    );

    seg_check i_check (
        .req_valid (la_valid),
        .la        (la),
        .ent       (rd_entry),
        .res       (res),
        .pa        (pa_comb)
    );

    seg_resp_reg i_resp (
        .clk     (clk),
        .rst     (rst),
        .res_d   (res),
        .pa_d    (pa_comb),
        .ok_q    (pa_valid),
        .fault_q (seg_fault),
        .pa_q    (pa_addr)
    );

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk
    import seg_xlat_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       la_valid,
    input logic                       sys_mode,
    input logic                       tw_en,
    input logic                       pa_valid,
    input logic                       seg_fault,
    input logic [PA_W-1:0]            pa_addr,
    input logic [NUM_SEG*ENTRY_W-1:0] tbl_bits
);

    p_one_outcome_r5: assert property (@(posedge clk) disable iff (rst)
        !(pa_valid && seg_fault));

    p_strobe_answered_r5: assert property (@(posedge clk) disable iff (rst)
        la_valid |=> (pa_valid || seg_fault));

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        !la_valid |=> (!pa_valid && !seg_fault));

    p_addr_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !pa_valid |-> (pa_addr == '0));

    p_user_write_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        !(tw_en && sys_mode) |=> $stable(tbl_bits));

    p_reset_clear_r8: assert property (@(posedge clk)
        $past(rst) |-> (!pa_valid && !seg_fault && pa_addr == '0));

endmodule

bind seg_xlat_top seg_xlat_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .la_valid  (la_valid),
    .sys_mode  (sys_mode),
    .tw_en     (tw_en),
    .pa_valid  (pa_valid),
    .seg_fault (seg_fault),
    .pa_addr   (pa_addr),
    .tbl_bits  (tbl_bits)
);

// File: tb/test_seg_xlat_top.sv
`timescale 1ns/1ps
module test_seg_xlat_top;
    import seg_xlat_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             la_valid;
    logic [LA_W-1:0]  la_addr;
    logic             sys_mode;
    logic             tw_en;
    logic [SEG_W-1:0] tw_index;
    logic [PA_W-1:0]  tw_base;
    logic [LIM_W-1:0] tw_limit;
    logic             tw_valid;
    logic             pa_valid;
    logic [PA_W-1:0]  pa_addr;
    logic             seg_fault;

    int n_checks = 0;
    int n_fails  = 0;

    logic [PA_W-1:0]  m_base [NUM_SEG];
    logic [LIM_W-1:0] m_lim  [NUM_SEG];
    logic             m_val  [NUM_SEG];

    always #4 clk = ~clk;

    seg_xlat_top i_seg_xlat_top (
        .clk(clk), .rst(rst), .la_valid(la_valid), .la_addr(la_addr),
        .sys_mode(sys_mode), .tw_en(tw_en), .tw_index(tw_index),
        .tw_base(tw_base), .tw_limit(tw_limit), .tw_valid(tw_valid),
        .pa_valid(pa_valid), .pa_addr(pa_addr), .seg_fault(seg_fault)
    );

    // Expected {pa_valid, seg_fault, pa_addr} from the bench's own table model.
    function automatic logic [PA_W+1:0] expect_out(input logic v,
                                                   input logic [SEG_W-1:0] s,
                                                   input logic [OFF_W-1:0] o);
        logic [PA_W-1:0] sum;
        if (!v) return '0;
        if (!m_val[s] || ({1'b0, o} >= m_lim[s])) return {1'b0, 1'b1, {PA_W{1'b0}}};
        sum = m_base[s] + {{(PA_W-OFF_W){1'b0}}, o};
        return {1'b1, 1'b0, sum};
    endfunction

    task automatic check(input string tag, input logic [PA_W+1:0] act,
                         input logic [PA_W+1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual valid/fault/pa=%0b/%0b/%h expected %0b/%0b/%h",
                     tag, act[PA_W+1], act[PA_W], act[PA_W-1:0],
                     exp[PA_W+1], exp[PA_W], exp[PA_W-1:0]);
        end
    endtask

    task automatic step(input logic v, input logic [SEG_W-1:0] s,
                        input logic [OFF_W-1:0] o, input logic m,
                        input logic we, input logic [SEG_W-1:0] wi,
                        input logic [PA_W-1:0] wb, input logic [LIM_W-1:0] wl,
                        input logic wv, input string tag);
        logic [PA_W+1:0] exp;
        @(negedge clk);
        la_valid = v;  la_addr = {s, o}; sys_mode = m;
        tw_en = we; tw_index = wi; tw_base = wb; tw_limit = wl; tw_valid = wv;
        exp = expect_out(v, s, o);
        @(posedge clk);
        #1;
        check(tag, {pa_valid, seg_fault, pa_addr}, exp);
        if (we && m) begin
            m_base[wi] = wb; m_lim[wi] = wl; m_val[wi] = wv;
        end
    endtask

    task automatic look(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o,
                        input string tag);
        step(1'b1, s, o, 1'b0, 1'b0, '0, '0, '0, 1'b0, tag);
    endtask

    task automatic load(input logic m, input logic [SEG_W-1:0] wi,
                        input logic [PA_W-1:0] wb, input logic [LIM_W-1:0] wl,
                        input logic wv, input string tag);
        step(1'b0, '0, '0, m, 1'b1, wi, wb, wl, wv, tag);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC7_0A11));
        for (int i = 0; i < NUM_SEG; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_val[i] = 1'b0;
        end
        rst = 1'b1; la_valid = 0; la_addr = '0; sys_mode = 0;
        tw_en = 0; tw_index = '0; tw_base = '0; tw_limit = '0; tw_valid = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset outputs", {pa_valid, seg_fault, pa_addr}, '0);
        @(negedge clk); rst = 1'b0;

        // R8: every entry starts invalid
        for (int s = 0; s < NUM_SEG; s++) look(SEG_W'(s), 12'h000, "R8 entry invalid after reset");

        // R2/R3 basic segment
        load(1'b1, 3'd0, 20'h10000, 13'h100, 1'b1, "R6 system load");
        look(3'd0, 12'h000, "R2 offset zero gives base");
        look(3'd0, 12'h0FF, "R3 last legal offset");
        look(3'd0, 12'h100, "R3 offset equal to limit faults");
        look(3'd0, 12'hFFF, "R3 large offset faults");
        step(1'b0, '0, '0, 1'b0, 1'b0, '0, '0, '0, 1'b0, "R5 R9 idle cycle");

        // R2 wrap and full-size limit
        load(1'b1, 3'd7, 20'hFFFFF, 13'h1000, 1'b1, "R6 system load top");
        look(3'd7, 12'h005, "R2 wrap modulo address space");
        look(3'd7, 12'hFFF, "R3 full-size limit admits max offset");

        // R3 zero limit, R4 invalid entry
        load(1'b1, 3'd3, 20'h00400, 13'h000, 1'b1, "R6 load zero length");
        look(3'd3, 12'h000, "R3 zero limit faults");
        load(1'b1, 3'd4, 20'h02000, 13'h800, 1'b0, "R6 load invalid");
        look(3'd4, 12'h001, "R4 invalid entry faults");

        // R6 user-mode write ignored
        load(1'b0, 3'd0, 20'hABCDE, 13'h1000, 1'b1, "R6 user write attempt");
        look(3'd0, 12'h010, "R6 user write had no effect");
        look(3'd0, 12'h200, "R6 old limit still enforced");

        // R7 same-cycle write and lookup
        step(1'b1, 3'd0, 12'h020, 1'b1, 1'b1, 3'd0, 20'h40000, 13'h40, 1'b1,
             "R7 lookup uses old contents");
        look(3'd0, 12'h020, "R7 next lookup uses new contents");
        look(3'd0, 12'h040, "R7 new limit enforced");

        // R1 field split: same offset, different segments
        load(1'b1, 3'd5, 20'h55000, 13'h1000, 1'b1, "R1 load seg5");
        load(1'b1, 3'd6, 20'h66000, 13'h1000, 1'b1, "R1 load seg6");
        look(3'd5, 12'h123, "R1 upper field selects seg5");
        look(3'd6, 12'h123, "R1 upper field selects seg6");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [SEG_W-1:0] s;
            logic [OFF_W-1:0] o;
            logic [LIM_W-1:0] lim;
            s   = SEG_W'($urandom);
            lim = LIM_W'($urandom_range(0, 1 << OFF_W));
            if ($urandom_range(0, 3) == 0)
                o = OFF_W'(m_lim[s] + LIM_W'($urandom_range(0, 2)) - LIM_W'(1));
            else
                o = OFF_W'($urandom);
            step($urandom_range(0, 3) != 0, s, o, 1'($urandom), $urandom_range(0, 4) == 0,
                 SEG_W'($urandom), PA_W'($urandom), lim, $urandom_range(0, 7) != 0,
                 "R1 R2 R3 R4 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule